// File: doc/BRIEF.md
# Performance-State Transition Controller

This block sets the operating point of one processor clock and voltage domain. Each core sharing the domain writes the performance-state index it wants into its own request register. The controller picks one target from the requests of the active cores and caps it when the thermal limit is raised. It reads the PLL multiplier and the regulator voltage code for that state from a computed table. It then moves the domain to the new point in a fixed order, with handshakes to the external voltage regulator and to the PLL.

Index 0 is the fastest and highest-voltage point. Larger indices are slower and lower. When the domain speeds up, the voltage is raised first and must settle before the multiplier changes. When it slows down, the multiplier drops first and the voltage follows once the PLL has relocked. A clock-gate request covers every multiplier change. If the regulator never reports settled, the controller gives up and sets a sticky error flag. The status output always shows the state that is fully applied, never the state that was requested.

Top module: `pstate_ctrl`

## Requirements
- R1: After reset the status is state 5, `vid_out` is 96, `pll_mult` is 6, and `clk_gate_req`, `busy` and `vr_err` are all 0.
- R2: For state index i, the applied multiplier is 16 - 2*i, which gives 16, 14, 12, 10, 8 and 6 on a 100 MHz reference. The applied voltage code is 148 - floor(i*52/5), which runs from 148 at index 0 down to 96 at index 5.
- R3: A write to a core's request register stores the written index, except that any index above 5 is stored as 5.
- R4: The target is the numerically smallest stored request among the cores whose `core_active` bit is 1. When no core is active, no transition starts.
- R5: While `therm_lim` is 1, the target is never better than the limit index. The limit index is `therm_idx`, saturated to 5.
- R6: On a move to a smaller index, `vid_out` takes the new code while `pll_mult` keeps its old value. `pll_mult` changes only after `vr_ready` has been seen.
- R7: On a move to a larger index, `pll_mult` takes the new value first. `vid_out` keeps its old code until `pll_lock` has been seen.
- R8: `clk_gate_req` rises in the same cycle that `pll_mult` changes. It stays high until `pll_lock` is seen, and `pll_mult` never changes while it is low.
- R9: If a regulator settle wait lasts 1024 cycles without `vr_ready`, `vr_err` is set and stays set until reset. `vid_out` and `pll_mult` return to the old state's values, and the status does not change.
- R10: A target equal to the state in effect starts no transition, so `busy` stays 0.
- R11: Once a transition has started, request, activity and thermal changes do not alter it. They are acted on only after the controller is back in idle.
- R12: `cur_state` changes only when a transition completes, and then it takes the newly applied index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | N_CORES | Per-core write strobe for the request registers |
| req_idx | input | IDX_W | Requested state index, shared by all write strobes |
| core_active | input | N_CORES | Marks which cores take part in target selection |
| therm_lim | input | 1 | Thermal or power cap active |
| therm_idx | input | IDX_W | Best state allowed while the cap is active |
| vr_ready | input | 1 | Regulator reports its output settled |
| pll_lock | input | 1 | PLL reports lock at the current multiplier |
| vid_out | output | VID_W | Voltage code driven to the regulator |
| pll_mult | output | MULT_W | Multiplier driven to the PLL |
| clk_gate_req | output | 1 | Holds the core clock off during a multiplier change |
| cur_state | output | IDX_W | Status: the state index fully in effect |
| busy | output | 1 | A transition is in progress |
| vr_err | output | 1 | Sticky regulator settle timeout flag |

## Verification
Several properties are checked on every cycle by the assertions. The multiplier never changes without the gate request high. The gate drops only after lock. The voltage code never falls while the multiplier is moving, and the multiplier never rises in a cycle where the voltage code moves. The status changes only on completion, and the error flag rises only out of a settle wait that had no ready. The assertions also cover request saturation and the thermal cap on the resolved target. Only the bench scenarios can show the values of the table, the minimum taken across active cores, and the fact that mid-transition request changes are deferred. They also show that a timeout restores the old operating point, which needs held-off handshakes and more than a thousand cycles of waiting.

// File: rtl/pstate_pkg.sv
// Shared definitions for the performance-state controller.
// Holds the sequencer state type and the operating-point formulas, which the
// table and the reset values both use.
package pstate_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_VOLT_UP,
        SQ_WAIT_VR,
        SQ_FREQ_CHANGE,
        SQ_WAIT_LOCK,
        SQ_VOLT_DOWN,
        SQ_WAIT_VR2,
        SQ_DONE
    } seq_state_e;

    // Multiplier for a state index: a fixed step below the top value per index.
    function automatic int op_mult(int idx, int top, int step);
        return top - step * idx;
    endfunction

    // Voltage code for a state index: linear between the end points, rounded down.
    function automatic int op_vid(int idx, int n_states, int top, int bot);
        return top - (idx * (top - bot)) / (n_states - 1);
    endfunction

endpackage

// File: rtl/pstate_req_regs.sv
// Per-core request registers.
// Each core has a write strobe that shares one index bus. Indices above the
// slowest state are saturated on write. Reset puts every request at the
// slowest state.
module pstate_req_regs #(
    parameter int N_CORES  = 4,
    parameter int N_STATES = 6,
    parameter int IDX_W    = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_CORES-1:0]              wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    output logic [N_CORES-1:0][IDX_W-1:0]   req_q
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_STATES - 1);

    logic [IDX_W-1:0] wr_sat;

    // Clamp the written index to the slowest valid state.
    always_comb wr_sat = (wr_idx > MAX_IDX) ? MAX_IDX : wr_idx;

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        // Capture one core's request on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          req_q[c] <= MAX_IDX;
            else if (wr_en[c])   req_q[c] <= wr_sat;
        end

        AST_REQ_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en[c] && wr_idx > MAX_IDX) |=> (req_q[c] == MAX_IDX)); // R3
    end

endmodule

// File: rtl/pstate_arbiter.sv
// Target resolution.
// Takes the smallest index, which is the best performance, over the active
// cores. Then applies the thermal cap, whose limit index is saturated to the
// slowest state. tgt_vld is low when no core is active.
module pstate_arbiter #(
    parameter int N_CORES  = 4,
    parameter int N_STATES = 6,
    parameter int IDX_W    = 3
) (
    input  logic [N_CORES-1:0][IDX_W-1:0]   req_q,
    input  logic [N_CORES-1:0]              core_active,
    input  logic                            therm_lim,
    input  logic [IDX_W-1:0]                therm_idx,
    output logic [IDX_W-1:0]                tgt,
    output logic                            tgt_vld
);
    localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(N_STATES - 1);

    logic [IDX_W-1:0] best;
    logic [IDX_W-1:0] cap;

    // Minimum over active requests, then the thermal clamp.
    always_comb begin
        best    = MAX_IDX;
        tgt_vld = 1'b0;
        for (int c = 0; c < N_CORES; c++) begin
            if (core_active[c] && req_q[c] < best) best = req_q[c];
            if (core_active[c]) tgt_vld = 1'b1;
        end
        cap = (therm_idx > MAX_IDX) ? MAX_IDX : therm_idx;
        tgt = (therm_lim && best < cap) ? cap : best;
    end

endmodule

// File: rtl/pstate_optable.sv
// Operating-point lookup.
// A computed table of multiplier and voltage code per state, read through one
// port. An out-of-range index reads the slowest entry.
module pstate_optable
    import pstate_pkg::*;
#(
    parameter int N_STATES  = 6,
    parameter int IDX_W     = 3,
    parameter int MULT_W    = 5,
    parameter int VID_W     = 8,
    parameter int MULT_TOP  = 16,
    parameter int MULT_STEP = 2,
    parameter int VID_TOP   = 148,
    parameter int VID_BOT   = 96
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [MULT_W-1:0] mult,
    output logic [VID_W-1:0]  vid
);
    logic [MULT_W-1:0] mult_tab [N_STATES];
    logic [VID_W-1:0]  vid_tab  [N_STATES];

    for (genvar s = 0; s < N_STATES; s++) begin : g_entry
        assign mult_tab[s] = MULT_W'(op_mult(s, MULT_TOP, MULT_STEP));
        assign vid_tab[s]  = VID_W'(op_vid(s, N_STATES, VID_TOP, VID_BOT));
    end

    logic in_range;

    // Select the entry, falling back to the slowest state.
    always_comb begin
        in_range = ({1'b0, idx} < (IDX_W+1)'(N_STATES));
        mult     = in_range ? mult_tab[idx] : mult_tab[N_STATES-1];
        vid      = in_range ? vid_tab[idx]  : vid_tab[N_STATES-1];
    end

endmodule

// File: rtl/pstate_seq.sv
// Transition sequencer.
// Assumes new_* describe tgt_q and old_* describe cur_state, both through
// table lookups outside. Raises voltage before frequency and lowers frequency
// before voltage. Waits for the regulator with a cycle timeout. On a timeout
// it restores the old point and commits nothing.
module pstate_seq
    import pstate_pkg::*;
#(
    parameter int IDX_W       = 3,
    parameter int MULT_W      = 5,
    parameter int VID_W       = 8,
    parameter int TIMEOUT_CYC = 1024,
    parameter logic [IDX_W-1:0]  RST_IDX  = '0,
    parameter logic [MULT_W-1:0] RST_MULT = '0,
    parameter logic [VID_W-1:0]  RST_VID  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  tgt,
    input  logic              tgt_vld,
    input  logic [MULT_W-1:0] new_mult,
    input  logic [VID_W-1:0]  new_vid,
    input  logic [MULT_W-1:0] old_mult,
    input  logic [VID_W-1:0]  old_vid,
    input  logic              vr_ready,
    input  logic              pll_lock,
    output logic [IDX_W-1:0]  tgt_q,
    output logic [IDX_W-1:0]  cur_state,
    output logic [VID_W-1:0]  vid_out,
    output logic [MULT_W-1:0] pll_mult,
    output logic              clk_gate_req,
    output logic              busy,
    output logic              vr_err
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e        st;
    logic              dn_q;
    logic              abort_q;
    logic [CNT_W-1:0]  wcnt;

    // Main sequencing of voltage, frequency and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= SQ_IDLE;
            tgt_q        <= RST_IDX;
            cur_state    <= RST_IDX;
            vid_out      <= RST_VID;
            pll_mult     <= RST_MULT;
            clk_gate_req <= 1'b0;
            vr_err       <= 1'b0;
            dn_q         <= 1'b0;
            abort_q      <= 1'b0;
            wcnt         <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    abort_q <= 1'b0;
                    if (tgt_vld && tgt != cur_state) begin
                        tgt_q <= tgt;
                        dn_q  <= (tgt > cur_state);
                        st    <= (tgt < cur_state) ? SQ_VOLT_UP : SQ_FREQ_CHANGE;
                    end
                end
                SQ_VOLT_UP: begin
                    vid_out <= new_vid;
                    wcnt    <= '0;
                    st      <= SQ_WAIT_VR;
                end
                SQ_WAIT_VR: begin
                    if (vr_ready) begin
                        st <= SQ_FREQ_CHANGE;
                    end else if (wcnt == CNT_LAST) begin
                        vr_err  <= 1'b1;
                        vid_out <= old_vid;
                        abort_q <= 1'b1;
                        st      <= SQ_DONE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                SQ_FREQ_CHANGE: begin
                    pll_mult     <= abort_q ? old_mult : new_mult;
                    clk_gate_req <= 1'b1;
                    st           <= SQ_WAIT_LOCK;
                end
                SQ_WAIT_LOCK: begin
                    if (pll_lock) begin
                        clk_gate_req <= 1'b0;
                        st <= (dn_q && !abort_q) ? SQ_VOLT_DOWN : SQ_DONE;
                    end
                end
                SQ_VOLT_DOWN: begin
                    vid_out <= new_vid;
                    wcnt    <= '0;
                    st      <= SQ_WAIT_VR2;
                end
                SQ_WAIT_VR2: begin
                    if (vr_ready) begin
                        st <= SQ_DONE;
                    end else if (wcnt == CNT_LAST) begin
                        vr_err  <= 1'b1;
                        vid_out <= old_vid;
                        abort_q <= 1'b1;
                        st      <= SQ_FREQ_CHANGE;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                SQ_DONE: begin
                    if (!abort_q) cur_state <= tgt_q;
                    st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Busy whenever the sequencer is away from idle.
    always_comb busy = (st != SQ_IDLE);

    AST_MULT_UNDER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mult != $past(pll_mult)) |-> clk_gate_req); // R8
    AST_GATE_DROP_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_gate_req) |-> $past(pll_lock)); // R8
    AST_MULT_UP_VOLT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_mult > $past(pll_mult)) |-> $stable(vid_out)); // R6
    AST_VOLT_DOWN_FREQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out < $past(vid_out)) |-> ($stable(pll_mult) && !clk_gate_req)); // R7
    AST_STATUS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != $past(cur_state)) |-> ($past(st) == SQ_DONE)); // R12
    AST_ERR_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_err) |-> (($past(st) == SQ_WAIT_VR || $past(st) == SQ_WAIT_VR2)
                          && !$past(vr_ready))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vr_err) |-> vr_err); // R9
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CNT_LAST); // R9

endmodule

// File: rtl/pstate_ctrl.sv
// Performance-state controller top.
// Chains the request registers, target resolution, two table lookups (target
// and current) and the transition sequencer. Regulator and PLL sit outside
// behind ready and lock inputs.
module pstate_ctrl
    import pstate_pkg::*;
#(
    parameter int N_CORES     = 4,
    parameter int N_STATES    = 6,
    parameter int MULT_W      = 5,
    parameter int VID_W       = 8,
    parameter int MULT_TOP    = 16,
    parameter int MULT_STEP   = 2,
    parameter int VID_TOP     = 148,
    parameter int VID_BOT     = 96,
    parameter int TIMEOUT_CYC = 1024,
    parameter int IDX_W       = $clog2(N_STATES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req_wr,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [N_CORES-1:0] core_active,
    input  logic               therm_lim,
    input  logic [IDX_W-1:0]   therm_idx,
    input  logic               vr_ready,
    input  logic               pll_lock,
    output logic [VID_W-1:0]   vid_out,
    output logic [MULT_W-1:0]  pll_mult,
    output logic               clk_gate_req,
    output logic [IDX_W-1:0]   cur_state,
    output logic               busy,
    output logic               vr_err
);
    localparam int                RST_I    = N_STATES - 1;
    localparam logic [IDX_W-1:0]  RST_IDX  = IDX_W'(RST_I);
    localparam logic [MULT_W-1:0] RST_MULT = MULT_W'(op_mult(RST_I, MULT_TOP, MULT_STEP));
    localparam logic [VID_W-1:0]  RST_VID  = VID_W'(op_vid(RST_I, N_STATES, VID_TOP, VID_BOT));

    logic [N_CORES-1:0][IDX_W-1:0] req_q;
    logic [IDX_W-1:0]  arb_tgt, tgt_q;
    logic              arb_vld;
    logic [MULT_W-1:0] new_mult, old_mult;
    logic [VID_W-1:0]  new_vid, old_vid;

    pstate_req_regs #(.N_CORES(N_CORES), .N_STATES(N_STATES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(req_wr), .wr_idx(req_idx), .req_q(req_q)
    );

    pstate_arbiter #(.N_CORES(N_CORES), .N_STATES(N_STATES), .IDX_W(IDX_W)) u_arb (
        .req_q(req_q), .core_active(core_active), .therm_lim(therm_lim),
        .therm_idx(therm_idx), .tgt(arb_tgt), .tgt_vld(arb_vld)
    );

    pstate_optable #(.N_STATES(N_STATES), .IDX_W(IDX_W), .MULT_W(MULT_W), .VID_W(VID_W),
                     .MULT_TOP(MULT_TOP), .MULT_STEP(MULT_STEP),
                     .VID_TOP(VID_TOP), .VID_BOT(VID_BOT)) u_tab_new (
        .idx(tgt_q), .mult(new_mult), .vid(new_vid)
    );

    pstate_optable #(.N_STATES(N_STATES), .IDX_W(IDX_W), .MULT_W(MULT_W), .VID_W(VID_W),
                     .MULT_TOP(MULT_TOP), .MULT_STEP(MULT_STEP),
                     .VID_TOP(VID_TOP), .VID_BOT(VID_BOT)) u_tab_old (
        .idx(cur_state), .mult(old_mult), .vid(old_vid)
    );

    pstate_seq #(.IDX_W(IDX_W), .MULT_W(MULT_W), .VID_W(VID_W), .TIMEOUT_CYC(TIMEOUT_CYC),
                 .RST_IDX(RST_IDX), .RST_MULT(RST_MULT), .RST_VID(RST_VID)) u_seq (
        .clk(clk), .rst_n(rst_n), .tgt(arb_tgt), .tgt_vld(arb_vld),
        .new_mult(new_mult), .new_vid(new_vid), .old_mult(old_mult), .old_vid(old_vid),
        .vr_ready(vr_ready), .pll_lock(pll_lock), .tgt_q(tgt_q), .cur_state(cur_state),
        .vid_out(vid_out), .pll_mult(pll_mult), .clk_gate_req(clk_gate_req),
        .busy(busy), .vr_err(vr_err)
    );

    AST_THERM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_lim && arb_vld) |->
        (arb_tgt >= ((therm_idx > RST_IDX) ? RST_IDX : therm_idx))); // R5

endmodule

// File: tb/pstate_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for pstate_ctrl: one task per scenario, each checking its own results.
module pstate_ctrl_bench;
    localparam int NC = 4;
    localparam int IW = 3;
    localparam int TO = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req_wr = '0;
    logic [IW-1:0] req_idx = '0;
    logic [NC-1:0] core_active = '0;
    logic          therm_lim = 1'b0;
    logic [IW-1:0] therm_idx = '0;
    logic          vr_ready = 1'b1;
    logic          pll_lock = 1'b1;
    logic [7:0]    vid_out;
    logic [4:0]    pll_mult;
    logic          clk_gate_req;
    logic [IW-1:0] cur_state;
    logic          busy;
    logic          vr_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pstate_ctrl u_pstate_ctrl (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_idx(req_idx),
        .core_active(core_active), .therm_lim(therm_lim), .therm_idx(therm_idx),
        .vr_ready(vr_ready), .pll_lock(pll_lock), .vid_out(vid_out),
        .pll_mult(pll_mult), .clk_gate_req(clk_gate_req), .cur_state(cur_state),
        .busy(busy), .vr_err(vr_err)
    );

    function automatic int x_mult(int i); return 16 - 2 * i; endfunction
    function automatic int x_vid(int i);  return 148 - (i * 52) / 5; endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_req(input int core, input int idx);
        @(negedge clk);
        req_wr = '0;
        req_wr[core] = 1'b1;
        req_idx = IW'(idx);
        @(negedge clk);
        req_wr = '0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    endtask

    task automatic check_point(input string tag, input int idx);
        check({tag, " status"}, cur_state, idx);
        check({tag, " mult"}, pll_mult, x_mult(idx));
        check({tag, " vid"}, vid_out, x_vid(idx));
    endtask

    task automatic t_reset();
        check_point("R1 reset", 5);
        check("R1 gate", clk_gate_req, 0);
        check("R1 busy", busy, 0);
        check("R1 err", vr_err, 0);
    endtask

    task automatic t_equal();
        int seen = 0;
        core_active = 4'b0001;
        write_req(0, 5);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        check("R10 no transition on equal", seen, 0);
    endtask

    task automatic t_up_order();
        vr_ready = 1'b0; pll_lock = 1'b0;
        write_req(0, 2);
        cycles(4);
        check("R6 vid first", vid_out, x_vid(2));
        check("R6 mult held", pll_mult, x_mult(5));
        check("R12 status held", cur_state, 5);
        vr_ready = 1'b1;
        cycles(3);
        check("R6 mult after ready", pll_mult, x_mult(2));
        check("R8 gate during lock wait", clk_gate_req, 1);
        pll_lock = 1'b1;
        wait_idle();
        check_point("R2 R12 up to 2", 2);
        check("R8 gate released", clk_gate_req, 0);
    endtask

    task automatic t_down_order();
        vr_ready = 1'b0; pll_lock = 1'b0;
        write_req(0, 4);
        cycles(4);
        check("R7 mult first", pll_mult, x_mult(4));
        check("R7 vid held", vid_out, x_vid(2));
        check("R8 gate", clk_gate_req, 1);
        pll_lock = 1'b1;
        cycles(3);
        check("R7 vid after lock", vid_out, x_vid(4));
        check("R12 status before settle", cur_state, 2);
        vr_ready = 1'b1;
        wait_idle();
        check_point("R2 down to 4", 4);
    endtask

    task automatic t_resolve();
        core_active = '0;
        write_req(1, 1);
        write_req(2, 3);
        write_req(3, 0);
        cycles(3);
        check("R4 none active", busy, 0);
        core_active = 4'b0111;
        wait_idle();
        check_point("R4 min of active", 1);
        core_active = '0;
        write_req(1, 5);
        cycles(4);
        check("R4 none active no move", cur_state, 1);
    endtask

    task automatic t_saturate();
        write_req(0, 7);
        core_active = 4'b0001;
        wait_idle();
        check_point("R3 saturated request", 5);
    endtask

    task automatic t_thermal();
        therm_idx = 3; therm_lim = 1'b1;
        write_req(0, 0);
        wait_idle();
        check_point("R5 capped at 3", 3);
        therm_lim = 1'b0;
        wait_idle();
        check_point("R5 cap removed", 0);
        therm_idx = 7; therm_lim = 1'b1;
        wait_idle();
        check_point("R5 cap index saturated", 5);
        therm_lim = 1'b0;
        wait_idle();
        check("R5 back to 0", cur_state, 0);
    endtask

    task automatic t_inflight();
        vr_ready = 1'b0; pll_lock = 1'b1;
        write_req(0, 2);
        cycles(2);
        write_req(0, 4);
        cycles(3);
        check("R11 in-flight target kept", vid_out, x_vid(2));
        vr_ready = 1'b1;
        wait_idle();
        check("R11 first transition done", cur_state, 2);
        wait_idle();
        check_point("R11 deferred request", 4);
    endtask

    task automatic t_timeout_up();
        vr_ready = 1'b0; pll_lock = 1'b1;
        write_req(0, 1);
        cycles(10);
        core_active = '0;
        check("R9 mult held while waiting", pll_mult, x_mult(4));
        cycles(TO - 30);
        check("R9 no error before limit", vr_err, 0);
        cycles(40);
        check("R9 error set", vr_err, 1);
        check_point("R9 up timeout restores", 4);
        check("R9 idle", busy, 0);
    endtask

    task automatic t_timeout_dn();
        core_active = '0;
        write_req(0, 5);
        vr_ready = 1'b0; pll_lock = 1'b1;
        core_active = 4'b0001;
        cycles(10);
        core_active = '0;
        check("R7 mult lowered", pll_mult, x_mult(5));
        cycles(TO + 20);
        check_point("R9 down timeout restores", 4);
        check("R9 error sticky", vr_err, 1);
        check("R9 gate off", clk_gate_req, 0);
        vr_ready = 1'b1;
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_equal();
        t_up_order();
        t_down_order();
        t_resolve();
        t_saturate();
        t_thermal();
        t_inflight();
        t_timeout_up();
        t_timeout_dn();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule